// File: doc/BRIEF.md
# DPSK Differential Demodulator

This block turns a received binary phase-modulated stream back into message bits without a carrier that stays coherent from bit to bit. It takes three inputs: the sign of the received waveform, as it comes out of a zero-crossing comparator; the sign of a carrier-phase reference; and a bit clock, which may come from the transmitter or from a local source. All three are asynchronous to the block's system clock. Each input passes through its own synchronizer lane, and every lane has the same depth so that the three stay aligned.

The block takes one sample in the middle of each bit period, at the falling edge of the bit clock. At that sample it forms an encoded phase bit: 1 when the received sign equals the reference sign. The encoded bit is held in a register, and the value that register held before the update acts as the one-bit delay. The message bit is the XNOR of the new encoded bit and the held one, so the recovered message trails the recovered encoded stream by one bit.

The first encoded bit after reset is the arbitrary starting bit of the stream. It is compared against a reset reference value, but it does not raise the valid strobe. If the local bit clock is not locked to the sender, some bits are sampled at the wrong place and the output is distorted. That effect belongs to the system, not to this block.

Top module: `dpsk_diff_demod`

## Requirements
- R1: While reset is asserted, and directly after it, enc_bit_o equals RESET_REF (default 0), msg_bit_o is 0 and msg_valid_o is 0.
- R2: At each sampling instant the captured encoded bit is 1 when the synchronized rx_sign_i equals the synchronized carrier_ref_i, and 0 when they differ. The carrier reference may change from bit to bit.
- R3: Sampling happens only at a falling edge of bit_clk_i. Changes on rx_sign_i while the bit clock is high, or after the falling edge has been sampled, have no effect on enc_bit_o or msg_bit_o. A rising edge of the bit clock captures nothing.
- R4: At each sample, msg_bit_o becomes 1 when the new encoded bit equals the previously held encoded bit, and 0 otherwise.
- R5: The first sample after reset compares against RESET_REF and updates msg_bit_o, but msg_valid_o stays low for that bit.
- R6: From the second sample after reset on, msg_valid_o is high for exactly one system clock per sample, in the same cycle that msg_bit_o takes the new value.
- R7: enc_bit_o, msg_bit_o and msg_valid_o change exactly SYNC_STAGES+1 system clocks (3 by default) after the bit clock's falling edge is applied at the input.
- R8: The received encoded sequence 0,1,1,1,0,1 yields exactly five valid message bits, 0,1,1,0,0, and enc_bit_o ends at 1.
- R9: A reset in the middle of a stream returns the block to the R1 state. The next sample is then treated as a first bit again, as in R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_sign_i | input | 1 | Sign of the received waveform from the zero-crossing comparator (asynchronous) |
| carrier_ref_i | input | 1 | Sign of the carrier-phase reference (asynchronous) |
| bit_clk_i | input | 1 | Bit clock; its falling edge marks mid-bit (asynchronous) |
| enc_bit_o | output | 1 | Most recently recovered encoded phase bit |
| msg_bit_o | output | 1 | Recovered message bit |
| msg_valid_o | output | 1 | One-cycle strobe for each valid message bit |

## Verification
On every cycle the assertions check four things: both outputs hold still whenever no sample strobe fires; each strobe is followed by a message bit equal to the XNOR of the new and old encoded values; the valid strobe lasts one cycle; and it never appears without a strobe in the cycle before. Other behaviour can only be shown by the directed scenarios:
- the exact latency from a bit-clock edge at the pins;
- whether sampling is insensitive to glitches in the other half of the bit;
- the suppressed first bit after reset;
- the recovery of the example sequence and of a longer pattern, with the carrier reference flipping from bit to bit.

// File: rtl/dpsk_pkg.sv
package dpsk_pkg;

  // Lanes carried through the input synchronizer.
  localparam int unsigned LANE_BCLK = 0;
  localparam int unsigned LANE_RX   = 1;
  localparam int unsigned LANE_CREF = 2;
  localparam int unsigned NUM_LANES = 3;

  // Encoded phase bit: 1 when received sign agrees with the reference sign.
  function automatic logic phase_match(input logic rx_s, input logic cref_s);
    return (rx_s == cref_s) ? 1'b1 : 1'b0;
  endfunction

  // Differential decode: 1 when two consecutive encoded bits agree.
  function automatic logic diff_decode(input logic cur_enc, input logic prev_enc);
    return ~(cur_enc ^ prev_enc);
  endfunction

endpackage

// File: rtl/dpsk_sync.sv
module dpsk_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/dpsk_bit_timer.sv
module dpsk_bit_timer (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_s,
  output logic sample_stb
);

  logic bclk_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bclk_prev_q <= 1'b0;
    else        bclk_prev_q <= bclk_s;
  end

  // Falling edge of the bit clock marks the middle of the bit.
  assign sample_stb = bclk_prev_q & ~bclk_s;

endmodule

// File: rtl/dpsk_phase_slicer.sv
module dpsk_phase_slicer
  import dpsk_pkg::*;
(
  input  logic rx_s,
  input  logic cref_s,
  output logic enc_next
);

  always_comb begin
    enc_next = phase_match(rx_s, cref_s);
  end

endmodule

// File: rtl/dpsk_diff_decoder.sv
module dpsk_diff_decoder
  import dpsk_pkg::*;
#(
  parameter logic RESET_REF = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_stb,
  input  logic enc_next,
  output logic enc_q,
  output logic msg_q,
  output logic valid_q
);

  logic primed_q;

  // enc_q is both the latched encoded bit and, before its update,
  // the one-bit delay that the new bit is compared against.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enc_q    <= RESET_REF;
      msg_q    <= 1'b0;
      valid_q  <= 1'b0;
      primed_q <= 1'b0;
    end else if (sample_stb) begin
      enc_q    <= enc_next;
      msg_q    <= diff_decode(enc_next, enc_q);
      valid_q  <= primed_q;
      primed_q <= 1'b1;
    end else begin
      valid_q  <= 1'b0;
    end
  end

endmodule

// File: rtl/dpsk_diff_demod.sv
module dpsk_diff_demod
  import dpsk_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic        RESET_REF   = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_sign_i,
  input  logic carrier_ref_i,
  input  logic bit_clk_i,
  output logic enc_bit_o,
  output logic msg_bit_o,
  output logic msg_valid_o
);

  logic [NUM_LANES-1:0] lanes_async;
  logic [NUM_LANES-1:0] lanes_sync;
  logic                 sample_stb;
  logic                 enc_next;

  always_comb begin
    lanes_async            = '0;
    lanes_async[LANE_BCLK] = bit_clk_i;
    lanes_async[LANE_RX]   = rx_sign_i;
    lanes_async[LANE_CREF] = carrier_ref_i;
  end

  dpsk_sync #(
    .WIDTH  (NUM_LANES),
    .STAGES (SYNC_STAGES)
  ) sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (lanes_async),
    .sync_o  (lanes_sync)
  );

  dpsk_bit_timer timer_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bclk_s     (lanes_sync[LANE_BCLK]),
    .sample_stb (sample_stb)
  );

  dpsk_phase_slicer slicer_i (
    .rx_s     (lanes_sync[LANE_RX]),
    .cref_s   (lanes_sync[LANE_CREF]),
    .enc_next (enc_next)
  );

  dpsk_diff_decoder #(
    .RESET_REF (RESET_REF)
  ) dec_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_stb (sample_stb),
    .enc_next   (enc_next),
    .enc_q      (enc_bit_o),
    .msg_q      (msg_bit_o),
    .valid_q    (msg_valid_o)
  );

endmodule

// File: rtl/dpsk_diff_demod_chk.sv
module dpsk_diff_demod_chk (
  input logic clk,
  input logic rst_n,
  input logic sample_stb,
  input logic enc_bit,
  input logic msg_bit,
  input logic msg_valid
);

  // R3: outputs move only after a sample strobe
  a_r3_hold_between_samples: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb |=> ($stable(enc_bit) && $stable(msg_bit)));

  // R4: message bit agrees with old/new encoded pair
  a_r4_xnor_decode: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> (msg_bit == ~(enc_bit ^ $past(enc_bit))));

  // R6: valid is a single-cycle pulse
  a_r6_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |=> !msg_valid);

  // R6: valid only ever follows a sample strobe
  a_r6_valid_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> $past(sample_stb));

endmodule

bind dpsk_diff_demod dpsk_diff_demod_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .sample_stb (sample_stb),
  .enc_bit    (enc_bit_o),
  .msg_bit    (msg_bit_o),
  .msg_valid  (msg_valid_o)
);

// File: tb/dpsk_diff_demod_tb_top.sv
`timescale 1ns/1ps
module dpsk_diff_demod_tb_top;

  localparam int HALF  = 6;   // system clocks per bit-clock half period
  localparam int LAT   = 3;   // SYNC_STAGES + 1

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_sign = 1'b0;
  logic cref = 1'b0;
  logic bclk = 1'b0;
  logic enc_bit, msg_bit, msg_valid;

  int checks = 0;
  int fails  = 0;
  int vcount = 0;
  logic vlog [64];
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dpsk_diff_demod dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_sign_i     (rx_sign),
    .carrier_ref_i (cref),
    .bit_clk_i     (bclk),
    .enc_bit_o     (enc_bit),
    .msg_bit_o     (msg_bit),
    .msg_valid_o   (msg_valid)
  );

  always @(negedge clk) begin
    if (msg_valid) begin
      if (vcount < 64) vlog[vcount] = msg_bit;
      vcount++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      fails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bclk = 1'b0; rx_sign = 1'b0; cref = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    vcount = 0;
  endtask

  // Send one encoded bit; ref flips the carrier sign seen for this bit.
  task automatic send_bit(input logic enc, input logic refv);
    bclk = 1'b1; cref = refv; rx_sign = enc ? refv : ~refv;
    repeat (HALF) @(negedge clk);
    bclk = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0; bclk = 1'b0;
    repeat (2) @(negedge clk);
    check(enc_bit == 1'b0, "R1 enc during reset", enc_bit, 0);
    check(msg_bit == 1'b0, "R1 msg during reset", msg_bit, 0);
    check(msg_valid == 1'b0, "R1 valid during reset", msg_valid, 0);
    do_reset();
    check(enc_bit == 1'b0 && msg_bit == 1'b0 && msg_valid == 1'b0,
          "R1 state after reset", {enc_bit, msg_bit, msg_valid}, 0);
  endtask

  task automatic t_first_bit();
    do_reset();
    send_bit(1'b0, 1'b1);
    check(msg_bit == 1'b1, "R5 first bit 0 vs ref 0", msg_bit, 1);
    check(vcount == 0, "R5 no valid on first bit", vcount, 0);
    do_reset();
    send_bit(1'b1, 1'b0);
    check(enc_bit == 1'b1, "R2 enc of matching signs", enc_bit, 1);
    check(msg_bit == 1'b0, "R5 first bit 1 vs ref 0", msg_bit, 0);
    check(vcount == 0, "R5 no valid on first bit (1)", vcount, 0);
    send_bit(1'b1, 1'b1);
    check(vcount == 1, "R6 valid from second bit", vcount, 1);
  endtask

  task automatic t_example();
    logic [5:0] enc_seq = 6'b011101;
    logic [4:0] msg_exp = 5'b01100;
    do_reset();
    for (int i = 5; i >= 0; i--) send_bit(enc_seq[i], logic'(i % 2));
    check(vcount == 5, "R8 five valid bits", vcount, 5);
    for (int k = 0; k < 5; k++)
      check(vlog[k] == msg_exp[4-k], "R8 message bit", vlog[k], msg_exp[4-k]);
    check(enc_bit == 1'b1, "R8 final encoded bit", enc_bit, 1);
  endtask

  task automatic t_long();
    logic [19:0] seq = 20'b01100011011001110010;
    int errs = 0;
    do_reset();
    for (int i = 19; i >= 0; i--) begin
      send_bit(seq[i], logic'((i / 3) % 2));
      check(enc_bit == seq[i], "R2 encoded bit recovered", enc_bit, seq[i]);
    end
    check(vcount == 19, "R6 one valid per bit", vcount, 19);
    for (int k = 1; k < 20; k++) begin
      logic e = (seq[20-k] == seq[19-k]);
      if (vlog[k-1] != e) errs++;
    end
    check(errs == 0, "R4 message pattern mismatches", errs, 0);
  endtask

  task automatic t_latency();
    do_reset();
    bclk = 1'b1; cref = 1'b1; rx_sign = 1'b1;
    repeat (HALF) @(negedge clk);
    bclk = 1'b0;
    repeat (LAT - 1) @(negedge clk);
    check(enc_bit == 1'b0, "R7 not yet updated", enc_bit, 0);
    @(negedge clk);
    check(enc_bit == 1'b1, "R7 updated at latency", enc_bit, 1);
    repeat (HALF) @(negedge clk);
  endtask

  task automatic t_ignore();
    do_reset();
    send_bit(1'b1, 1'b0);
    send_bit(1'b1, 1'b0);
    bclk = 1'b1; cref = 1'b0;
    for (int c = 0; c < HALF; c++) begin
      rx_sign = ~rx_sign;
      @(negedge clk);
    end
    check(enc_bit == 1'b1, "R3 rising/high half ignored", enc_bit, 1);
    rx_sign = 1'b1;              // final value: enc 0 (differs from ref 0)
    @(negedge clk);
    bclk = 1'b0;
    @(negedge clk);
    for (int c = 0; c < HALF; c++) begin
      rx_sign = ~rx_sign;
      @(negedge clk);
    end
    rx_sign = 1'b0;
    repeat (HALF) @(negedge clk);
    check(enc_bit == 1'b0, "R3 low-half changes ignored", enc_bit, 0);
    check(msg_bit == 1'b0, "R3 message from mid-bit sample", msg_bit, 0);
  endtask

  task automatic t_mid_reset();
    do_reset();
    send_bit(1'b1, 1'b1);
    send_bit(1'b1, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(enc_bit == 1'b0 && msg_bit == 1'b0, "R9 state cleared",
          {enc_bit, msg_bit}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    vcount = 0;
    send_bit(1'b1, 1'b1);
    check(msg_bit == 1'b0 && vcount == 0, "R9 re-primed first bit",
          {msg_bit, 1'(vcount != 0)}, 0);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_first_bit();
    t_example();
    t_long();
    t_latency();
    t_ignore();
    t_mid_reset();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule